// File: doc/BRIEF.md
# Low-Power Mode Entry Sequencer

This block decides when a small microcontroller subsystem may drop into a low-power state, and which state that is. It watches the busy flag of a DMA engine and a set of software-written control bits. Those bits are a module-stop bit for the DMA engine, a module-stop bit for each of the other peripherals, an enable for all-module clock stop, a standby select and a deep-standby select. A one-cycle WAIT pulse from the processor asks for a transition. The wake sources are a non-maskable interrupt, 16 external interrupt lines, a timer interrupt and a watchdog interrupt. An external active-low reset returns the block to the run state. The reset is asserted asynchronously and released through a two-flop synchronizer.

The block never gates the DMA clock while a transfer is in progress. A module-stop request, and any WAIT-triggered transition, waits until the DMA busy flag has dropped. The block reports the DMA clock enable, a register-access enable for the DMA engine and a 3-bit power-state code. Generating the clocks and the DMA datapath are outside this block.

Power-state codes: 0 run, 1 DMA module-stop pending, 2 all-module clock stop, 3 software standby, 4 deep standby, 5 DMA module stopped, 6 entry in progress (WAIT accepted, transition not yet taken).

Top module: `lp_entry_seq`

## Requirements
- R1: While reset is asserted, the outputs show `pwr_state`=0, `dma_clk_en`=1 and `dma_reg_acc`=1 (with `mstop_dma`=0).
- R2: After `mstop_dma` rises, the DMA clock stays enabled and `pwr_state`=1 for as long as `dma_busy`=1. In the cycle after `dma_busy` is sampled low, `dma_clk_en`=0 and `pwr_state`=5. If the DMA engine is idle, this happens one cycle after `mstop_dma` is sampled high.
- R3: `dma_reg_acc` is 0 in the same cycle in which `mstop_dma`=1, whether or not a transfer is running.
- R4: After `mstop_dma` returns to 0 in the stopped state, `dma_clk_en` is 1 one cycle later. `dma_reg_acc` is 1 one cycle after that, once the clock has run for a full cycle.
- R5: A WAIT pulse with `stby_sel`=1 and `deep_sel`=0 shows `pwr_state`=6 in the next cycle and then 3 (software standby), with `dma_clk_en`=0.
- R6: A WAIT pulse with `stby_sel`=1 and `deep_sel`=1 leads through state 6 to state 4 (deep standby).
- R7: With `stby_sel`=0, a WAIT pulse leads to state 2 (all-module clock stop) only if `acs_en`=1, `mstop_dma`=1 and every bit of `mstop_periph` is 1. Otherwise the WAIT matches nothing: `pwr_state` shows 6 for one cycle, then returns to run, and the DMA clock enable is not changed.
- R8: While `dma_busy`=1, a WAIT-triggered transition is held in state 6 with the DMA clock still running. It is taken in the cycle after `dma_busy` is sampled low.
- R9: From state 2 or 3, any one wake source (`nmi`, any bit of `ext_irq`, `tmr_irq`, `wdt_irq`) returns the block to run in the next cycle.
- R10: Deep standby (state 4) ignores all interrupt wake sources and is left only through reset.
- R11: A wake source that is active while the block is in state 6 cancels the pending entry, and the block goes back to run.
- R12: Asserting `rst_n` returns the block to run immediately from any state and clears any pending request.
- R13: The mode selection is latched when WAIT is sampled. Changing the control bits while entry is deferred does not change the state that is finally entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | External reset, active low, asynchronous assert |
| dma_busy | input | 1 | DMA transfer in progress |
| mstop_dma | input | 1 | Module-stop request for the DMA engine |
| mstop_periph | input | NUM_PERIPH | Module-stop bits of the other peripherals |
| acs_en | input | 1 | All-module clock-stop enable |
| stby_sel | input | 1 | Standby select on WAIT |
| deep_sel | input | 1 | Deep-standby select on WAIT |
| wait_pulse | input | 1 | One-cycle WAIT execution strobe |
| nmi | input | 1 | Non-maskable interrupt wake |
| ext_irq | input | NUM_EXT_IRQ | External interrupt wake lines |
| tmr_irq | input | 1 | Timer interrupt wake |
| wdt_irq | input | 1 | Watchdog interrupt wake |
| dma_clk_en | output | 1 | DMA clock gate enable |
| dma_reg_acc | output | 1 | DMA register access enable |
| pwr_state | output | 3 | Current power-state code |

## Verification
The bench builds the block with `NUM_PERIPH`=6 and `NUM_EXT_IRQ`=16. With six peripheral mask bits, the bench can clear each bit in turn and show that any single clear bit blocks all-module clock stop. With the full 16 interrupt lines, the bench can try the lowest and highest lines as wake sources. The bench also holds the DMA busy flag high across several cycles. This exercises the deferred paths for module stop and for WAIT, including a wake that cancels a deferred entry and control bits that change while entry is deferred.

// File: rtl/lp_seq_pkg.sv
package lp_seq_pkg;

  typedef enum logic [2:0] {
    PS_RUN        = 3'd0,
    PS_MSTOP_PEND = 3'd1,
    PS_ALLSTOP    = 3'd2,
    PS_SSTBY      = 3'd3,
    PS_DSTBY      = 3'd4,
    PS_MSTOPPED   = 3'd5,
    PS_ENTRY      = 3'd6
  } pstate_e;

  typedef enum logic [1:0] {
    GT_ON   = 2'd0,
    GT_PEND = 2'd1,
    GT_OFF  = 2'd2
  } gate_e;

  typedef enum logic [1:0] {
    TG_NONE    = 2'd0,
    TG_ALLSTOP = 2'd1,
    TG_SSTBY   = 2'd2,
    TG_DSTBY   = 2'd3
  } target_e;

endpackage

// File: rtl/lp_wake_merge.sv
module lp_wake_merge #(
  parameter int NUM_EXT_IRQ = 16
) (
  input  logic                   nmi,
  input  logic [NUM_EXT_IRQ-1:0] ext_irq,
  input  logic                   tmr_irq,
  input  logic                   wdt_irq,
  output logic                   wake
);
  localparam int NSRC = NUM_EXT_IRQ + 3;

  logic [NSRC-1:0] src;
  logic [NSRC:0]   chain;

  assign src = {wdt_irq, tmr_irq, nmi, ext_irq};

  assign chain[0] = 1'b0;
  for (genvar i = 0; i < NSRC; i++) begin : g_or
    assign chain[i+1] = chain[i] | src[i];
  end

  assign wake = chain[NSRC];
endmodule

// File: rtl/lp_mode_select.sv
module lp_mode_select
  import lp_seq_pkg::*;
#(
  parameter int NUM_PERIPH = 8
) (
  input  logic                  acs_en,
  input  logic                  stby_sel,
  input  logic                  deep_sel,
  input  logic                  mstop_dma,
  input  logic [NUM_PERIPH-1:0] mstop_periph,
  output target_e               target
);
  logic all_stopped;

  assign all_stopped = mstop_dma & (&mstop_periph);

  always_comb begin
    if (stby_sel) begin
      target = deep_sel ? TG_DSTBY : TG_SSTBY;
    end else if (acs_en && all_stopped) begin
      target = TG_ALLSTOP;
    end else begin
      target = TG_NONE;
    end
  end
endmodule

// File: rtl/lp_dma_gate.sv
module lp_dma_gate
  import lp_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  mstop_dma,
  input  logic  dma_busy,
  output gate_e gate
);
  gate_e gate_q, gate_d;

  always_comb begin
    gate_d = gate_q;
    case (gate_q)
      GT_ON: begin
        if (mstop_dma) gate_d = dma_busy ? GT_PEND : GT_OFF;
      end
      GT_PEND: begin
        if (!mstop_dma)    gate_d = GT_ON;
        else if (!dma_busy) gate_d = GT_OFF;
      end
      GT_OFF: begin
        if (!mstop_dma) gate_d = GT_ON;
      end
      default: gate_d = GT_ON;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= GT_ON;
    else        gate_q <= gate_d;
  end

  assign gate = gate_q;

  // R2: a stop request during a transfer must not stop the clock yet
  a_r2_defer_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q == GT_ON && mstop_dma && dma_busy) |=> (gate_q == GT_PEND));

  // R2: pending stays pending while the transfer continues
  a_r2_hold_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q == GT_PEND && mstop_dma && dma_busy) |=> (gate_q == GT_PEND));

  // R4: release of the request always restarts the clock
  a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q == GT_OFF && !mstop_dma) |=> (gate_q == GT_ON));
endmodule

// File: rtl/lp_core_fsm.sv
module lp_core_fsm
  import lp_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wait_pulse,
  input  logic    wake,
  input  logic    dma_busy,
  input  target_e target,
  output pstate_e core_state
);
  pstate_e state_q, state_d;
  target_e tgt_q, tgt_d;
  logic    tgt_load;

  assign tgt_load = (state_q == PS_RUN) && wait_pulse;
  assign tgt_d    = tgt_load ? target : tgt_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      PS_RUN: begin
        if (wait_pulse) state_d = PS_ENTRY;
      end
      PS_ENTRY: begin
        if (wake || tgt_q == TG_NONE) begin
          state_d = PS_RUN;
        end else if (!dma_busy) begin
          case (tgt_q)
            TG_ALLSTOP: state_d = PS_ALLSTOP;
            TG_SSTBY:   state_d = PS_SSTBY;
            TG_DSTBY:   state_d = PS_DSTBY;
            default:    state_d = PS_RUN;
          endcase
        end
      end
      PS_ALLSTOP, PS_SSTBY: begin
        if (wake) state_d = PS_RUN;
      end
      PS_DSTBY: state_d = PS_DSTBY;
      default:  state_d = PS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_RUN;
      tgt_q   <= TG_NONE;
    end else begin
      state_q <= state_d;
      tgt_q   <= tgt_d;
    end
  end

  assign core_state = state_q;

  // R8: entry is held while the DMA engine is busy
  a_r8_defer_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_ENTRY && dma_busy && !wake && tgt_q != TG_NONE)
      |=> (state_q == PS_ENTRY));

  // R11: a wake during deferral cancels entry
  a_r11_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_ENTRY && wake) |=> (state_q == PS_RUN));

  // R9: wake leaves clock stop and standby
  a_r9_wake_exit: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == PS_ALLSTOP || state_q == PS_SSTBY) && wake) |=> (state_q == PS_RUN));

  // R10: deep standby is left only by reset
  a_r10_deep_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_DSTBY) |=> (state_q == PS_DSTBY));

  // R13: the latched target does not move once entry is in progress
  a_r13_tgt_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_ENTRY) |=> $stable(tgt_q));
endmodule

// File: rtl/lp_entry_seq.sv
module lp_entry_seq
  import lp_seq_pkg::*;
#(
  parameter int NUM_PERIPH  = 8,
  parameter int NUM_EXT_IRQ = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   dma_busy,
  input  logic                   mstop_dma,
  input  logic [NUM_PERIPH-1:0]  mstop_periph,
  input  logic                   acs_en,
  input  logic                   stby_sel,
  input  logic                   deep_sel,
  input  logic                   wait_pulse,
  input  logic                   nmi,
  input  logic [NUM_EXT_IRQ-1:0] ext_irq,
  input  logic                   tmr_irq,
  input  logic                   wdt_irq,
  output logic                   dma_clk_en,
  output logic                   dma_reg_acc,
  output logic [2:0]             pwr_state
);
  logic    rst_s1_q, rst_sync_n;
  logic    wake;
  target_e target;
  gate_e   gate;
  pstate_e core_state;
  logic    lp_gated;
  logic    clk_ran_q;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1_q   <= 1'b1;
      rst_sync_n <= rst_s1_q;
    end
  end

  lp_wake_merge #(.NUM_EXT_IRQ(NUM_EXT_IRQ)) u_wake (
    .nmi     (nmi),
    .ext_irq (ext_irq),
    .tmr_irq (tmr_irq),
    .wdt_irq (wdt_irq),
    .wake    (wake)
  );

  lp_mode_select #(.NUM_PERIPH(NUM_PERIPH)) u_sel (
    .acs_en       (acs_en),
    .stby_sel     (stby_sel),
    .deep_sel     (deep_sel),
    .mstop_dma    (mstop_dma),
    .mstop_periph (mstop_periph),
    .target       (target)
  );

  lp_dma_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .mstop_dma (mstop_dma),
    .dma_busy  (dma_busy),
    .gate      (gate)
  );

  lp_core_fsm u_core (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wait_pulse (wait_pulse),
    .wake       (wake),
    .dma_busy   (dma_busy),
    .target     (target),
    .core_state (core_state)
  );

  assign lp_gated = (core_state == PS_ALLSTOP) || (core_state == PS_SSTBY) ||
                    (core_state == PS_DSTBY);

  assign dma_clk_en = (gate != GT_OFF) && !lp_gated;

  // clock must have run for a full cycle before registers reopen
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) clk_ran_q <= 1'b1;
    else             clk_ran_q <= dma_clk_en;
  end

  assign dma_reg_acc = !mstop_dma && dma_clk_en && clk_ran_q;

  always_comb begin
    if (core_state != PS_RUN)  pwr_state = core_state;
    else if (gate == GT_PEND)  pwr_state = PS_MSTOP_PEND;
    else if (gate == GT_OFF)   pwr_state = PS_MSTOPPED;
    else                       pwr_state = PS_RUN;
  end

  // R3: no register access while the stop request is set
  a_r3_no_access: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mstop_dma |-> !dma_reg_acc);

  // R5: no DMA clock in any low-power state
  a_r5_gated_lp: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pwr_state == 3'd2 || pwr_state == 3'd3 || pwr_state == 3'd4) |-> !dma_clk_en);

  // R2: the DMA clock never stops during a transfer in run state
  a_r2_clk_busy: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pwr_state == 3'd1) |-> dma_clk_en);
endmodule

// File: tb/tb_lp_entry_seq.sv
`timescale 1ns/1ps
module tb_lp_entry_seq;
  localparam int NP = 6;
  localparam int NI = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic dma_busy, mstop_dma, acs_en, stby_sel, deep_sel, wait_pulse;
  logic nmi, tmr_irq, wdt_irq;
  logic [NP-1:0] mstop_periph;
  logic [NI-1:0] ext_irq;
  logic dma_clk_en, dma_reg_acc;
  logic [2:0] pwr_state;

  int nvec = 0;
  int nerr = 0;

  always #2.5 clk = ~clk;

  lp_entry_seq #(.NUM_PERIPH(NP), .NUM_EXT_IRQ(NI)) dut (
    .clk(clk), .rst_n(rst_n), .dma_busy(dma_busy), .mstop_dma(mstop_dma),
    .mstop_periph(mstop_periph), .acs_en(acs_en), .stby_sel(stby_sel),
    .deep_sel(deep_sel), .wait_pulse(wait_pulse), .nmi(nmi), .ext_irq(ext_irq),
    .tmr_irq(tmr_irq), .wdt_irq(wdt_irq), .dma_clk_en(dma_clk_en),
    .dma_reg_acc(dma_reg_acc), .pwr_state(pwr_state)
  );

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    dma_busy = 0; mstop_dma = 0; acs_en = 0; stby_sel = 0; deep_sel = 0;
    wait_pulse = 0; nmi = 0; tmr_irq = 0; wdt_irq = 0;
    mstop_periph = '0; ext_irq = '0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    #1;
    tick();
    rst_n = 1;
    repeat (3) tick();
  endtask

  task automatic issue_wait();
    wait_pulse = 1;
    tick();
    wait_pulse = 0;
  endtask

  task automatic t_r1_reset();
    idle_inputs();
    rst_n = 0;
    #3;
    chk("R1 state", pwr_state, 0);
    chk("R1 clk_en", dma_clk_en, 1);
    chk("R1 reg_acc", dma_reg_acc, 1);
    tick();
    rst_n = 1;
    repeat (3) tick();
  endtask

  task automatic t_r2_r3_r4_module_stop();
    dma_busy = 1;
    mstop_dma = 1;
    #0.5;
    chk("R3 reg_acc same cycle busy", dma_reg_acc, 0);
    tick();
    chk("R2 pending state", pwr_state, 1);
    chk("R2 clk kept while busy", dma_clk_en, 1);
    tick();
    chk("R2 still pending", pwr_state, 1);
    chk("R2 clk still on", dma_clk_en, 1);
    dma_busy = 0;
    tick();
    chk("R2 stopped state", pwr_state, 5);
    chk("R2 clk gated", dma_clk_en, 0);
    mstop_dma = 0;
    tick();
    chk("R4 clk back", dma_clk_en, 1);
    chk("R4 reg still closed", dma_reg_acc, 0);
    chk("R4 state run", pwr_state, 0);
    tick();
    chk("R4 reg reopened", dma_reg_acc, 1);
    // idle engine: direct stop
    mstop_dma = 1;
    tick();
    chk("R2 idle stop", pwr_state, 5);
    chk("R2 idle clk gated", dma_clk_en, 0);
    mstop_dma = 0;
    repeat (2) tick();
  endtask

  task automatic t_r5_sstby();
    stby_sel = 1; deep_sel = 0;
    issue_wait();
    chk("R5 entry", pwr_state, 6);
    tick();
    chk("R5 standby", pwr_state, 3);
    chk("R5 clk gated", dma_clk_en, 0);
    nmi = 1;
    tick();
    nmi = 0;
    chk("R9 nmi wake", pwr_state, 0);
    chk("R9 clk back", dma_clk_en, 1);
    stby_sel = 0;
    tick();
  endtask

  task automatic t_r9_sources();
    for (int k = 0; k < 4; k++) begin
      stby_sel = 1;
      issue_wait();
      tick();
      chk("R9 in standby", pwr_state, 3);
      case (k)
        0: ext_irq[0] = 1'b1;
        1: ext_irq[NI-1] = 1'b1;
        2: tmr_irq = 1;
        default: wdt_irq = 1;
      endcase
      tick();
      ext_irq = '0; tmr_irq = 0; wdt_irq = 0;
      chk($sformatf("R9 wake source %0d", k), pwr_state, 0);
      stby_sel = 0;
      tick();
    end
  endtask

  task automatic t_r6_r10_r12_deep();
    stby_sel = 1; deep_sel = 1;
    issue_wait();
    chk("R6 entry", pwr_state, 6);
    tick();
    chk("R6 deep standby", pwr_state, 4);
    nmi = 1; wdt_irq = 1; ext_irq = '1; tmr_irq = 1;
    repeat (3) tick();
    chk("R10 deep ignores wake", pwr_state, 4);
    chk("R10 clk stays gated", dma_clk_en, 0);
    nmi = 0; wdt_irq = 0; ext_irq = '0; tmr_irq = 0;
    stby_sel = 0; deep_sel = 0;
    rst_n = 0;
    #1;
    chk("R12 reset leaves deep", pwr_state, 0);
    chk("R12 clk on", dma_clk_en, 1);
    tick();
    rst_n = 1;
    repeat (3) tick();
    chk("R12 run after release", pwr_state, 0);
  endtask

  task automatic t_r7_allstop();
    acs_en = 1; mstop_dma = 1; mstop_periph = '1;
    repeat (2) tick();
    chk("R7 dma stopped first", pwr_state, 5);
    issue_wait();
    chk("R7 entry", pwr_state, 6);
    tick();
    chk("R7 all-clock stop", pwr_state, 2);
    wdt_irq = 1;
    tick();
    wdt_irq = 0;
    chk("R9 wdt wake to stopped dma", pwr_state, 5);
    for (int i = 0; i < NP; i++) begin
      mstop_periph = '1;
      mstop_periph[i] = 1'b0;
      issue_wait();
      chk($sformatf("R7 bit %0d entry", i), pwr_state, 6);
      tick();
      chk($sformatf("R7 bit %0d no match", i), pwr_state, 5);
    end
    // DMA bit clear blocks too, clock untouched
    mstop_periph = '1; mstop_dma = 0;
    tick();
    tick();
    issue_wait();
    chk("R7 dma bit clear entry", pwr_state, 6);
    chk("R7 clk untouched", dma_clk_en, 1);
    tick();
    chk("R7 dma bit clear no match", pwr_state, 0);
    // enable clear blocks
    acs_en = 0; mstop_dma = 1;
    tick();
    issue_wait();
    tick();
    chk("R7 acs disabled no match", pwr_state, 5);
    mstop_dma = 0; mstop_periph = '0;
    repeat (2) tick();
  endtask

  task automatic t_r8_r13_defer();
    dma_busy = 1; stby_sel = 1; deep_sel = 0;
    issue_wait();
    stby_sel = 0; deep_sel = 1;
    chk("R8 entry", pwr_state, 6);
    tick();
    chk("R8 held while busy", pwr_state, 6);
    chk("R8 clk running", dma_clk_en, 1);
    tick();
    chk("R8 still held", pwr_state, 6);
    dma_busy = 0;
    tick();
    chk("R13 latched target standby", pwr_state, 3);
    tmr_irq = 1;
    tick();
    tmr_irq = 0; deep_sel = 0;
    chk("R9 tmr wake", pwr_state, 0);
  endtask

  task automatic t_r11_cancel();
    dma_busy = 1; stby_sel = 1;
    issue_wait();
    tick();
    chk("R11 deferred", pwr_state, 6);
    ext_irq[5] = 1'b1;
    tick();
    ext_irq = '0;
    chk("R11 cancelled", pwr_state, 0);
    dma_busy = 0;
    tick();
    chk("R11 stays run", pwr_state, 0);
    stby_sel = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    idle_inputs();
    t_r1_reset();
    t_r2_r3_r4_module_stop();
    t_r5_sstby();
    t_r9_sources();
    t_r6_r10_r12_deep();
    t_r7_allstop();
    t_r8_r13_defer();
    t_r11_cancel();
    do_reset();
    chk("R12 final run", pwr_state, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule